// File: doc/BRIEF.md
# Mode-Banked Status and Link Register File

This block keeps the processor status word of a small core, together with the link registers and saved-status registers that are banked by processor mode. The mode field in the low five bits of the status word decides which banked copy the register port reads and writes. Each mode that is not user or system has its own link register and its own saved-status register. User and system share one link register and have no saved-status register.

Five event inputs update the block: an interrupt-entry strobe, a call strobe, an exception-return strobe, a direct status write, and a register-port write. On interrupt entry, the outgoing status word and the return address go into the interrupt mode's own banks. The mode then becomes interrupt mode, the interrupt-disable bit is set, and a fixed vector is offered as the next PC. An exception return that asks for a status restore loads the PC and the restored status word in the same clock edge. The core therefore never runs in the new mode with the old PC, or in the old mode with the new PC.

The status word, the PC-load pulse, the PC value and the error pulse are all registered. They change in the cycle after the edge that accepts the event. The register read port is combinational and follows the current mode.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset the status word is 0x93: supervisor mode (mode field 5'b10011 in bits [4:0]) and the interrupt-disable bit (bit 7) set. Every banked link and saved-status register reads zero, and `pc_load_valid` and `eret_err` are low.
- R2: The mode encodings are user 5'b10000, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. With `reg_sel`=0 the port reads and writes the link copy of the current mode, and user and system share one copy.
- R3: On `irq_take`, the interrupt mode's saved-status register receives the status word that was current before entry. The new status word has mode 5'b10010 and bit 7 set, and all other bits are kept. The saved-status register of the mode being left is not changed.
- R4: On `irq_take`, `irq_ret_addr` is written into the interrupt mode's link register. The link register of the interrupted mode keeps its value.
- R5: The cycle after `irq_take` is accepted, `pc_load_valid` is high for one cycle and `pc_load` equals the vector 0x18.
- R6: `call_take` writes `call_ret_addr` into the link register of the current mode.
- R7: `stat_we` replaces the status word with `stat_wdata`. No banked register is copied, and `pc_load_valid` stays low.
- R8: `eret_take` with `eret_restore` set in interrupt, supervisor, abort or undefined mode loads the current mode's saved status into the status word and raises `pc_load_valid` with `pc_load`=`eret_pc`. Both become visible in the same cycle.
- R9: `eret_take` with `eret_restore` clear loads the PC and leaves the status word unchanged.
- R10: `eret_take` with `eret_restore` set in user or system mode leaves the status word unchanged, still loads the PC, and pulses `eret_err` high for exactly one cycle.
- R11: With `reg_sel`=1 the port reads and writes the current mode's saved-status register. In user or system mode a read returns zero and a write is ignored.
- R12: When several events arrive in the same cycle, only one takes effect, in this priority order: `irq_take`, `eret_take`, `call_take`, `stat_we`, `reg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 1 | Port target: 0 selects the link register, 1 selects the saved-status register |
| reg_we | input | 1 | Port write enable |
| reg_wdata | input | DATA_W | Port write data |
| reg_rdata | output | DATA_W | Port read data for the current mode (combinational) |
| irq_take | input | 1 | Interrupt-entry strobe |
| irq_ret_addr | input | DATA_W | Return address saved on interrupt entry |
| call_take | input | 1 | Call strobe |
| call_ret_addr | input | DATA_W | Return address saved by a call |
| eret_take | input | 1 | Exception-return strobe |
| eret_pc | input | DATA_W | PC to load on exception return |
| eret_restore | input | 1 | Restore the status word from the saved status on return |
| stat_we | input | 1 | Direct status-word write |
| stat_wdata | input | DATA_W | New status word |
| cur_mode | output | 5 | Current mode field |
| status | output | DATA_W | Current status word |
| pc_load_valid | output | 1 | One-cycle PC-load pulse |
| pc_load | output | DATA_W | PC value to load |
| eret_err | output | 1 | Pulse for a restore-flagged return without a saved-status register |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, the interrupt-disable bit at position 7 and vector 0x18. These are the values that the reset word 0x93 and the interrupt-mode word 0x92 depend on.

With these values, one run walks the core through supervisor, interrupt, user, system, abort and undefined modes. It checks several things along the way:
- the interrupt mode's saved-status and link copies are filled while the supervisor link register stays intact;
- the shared user/system link register behaves as one copy;
- the restore-flagged return behaves correctly both where a saved status exists and where it does not;
- simultaneous strobes obey the priority order.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
   localparam int MODE_W = 5;

   localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

   localparam int NUM_BANKS = 5;
   localparam int BANK_W    = $clog2(NUM_BANKS);

   // bank 0 is shared by user and system and has no saved-status copy
   typedef enum logic [BANK_W-1:0] {
      BANK_USR = 3'd0,
      BANK_IRQ = 3'd1,
      BANK_SVC = 3'd2,
      BANK_ABT = 3'd3,
      BANK_UND = 3'd4
   } bank_e;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_IRQ,
      EV_ERET,
      EV_CALL,
      EV_STAT,
      EV_PORT
   } event_e;
endpackage

// File: rtl/mbrf_mode_decode.sv
module mbrf_mode_decode
   import mbrf_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output bank_e             bank,
   output logic              has_saved
);
   always_comb begin
      bank      = BANK_USR;
      has_saved = 1'b0;
      case (mode)
         MODE_IRQ: begin bank = BANK_IRQ; has_saved = 1'b1; end
         MODE_SVC: begin bank = BANK_SVC; has_saved = 1'b1; end
         MODE_ABT: begin bank = BANK_ABT; has_saved = 1'b1; end
         MODE_UND: begin bank = BANK_UND; has_saved = 1'b1; end
         default:  begin bank = BANK_USR; has_saved = 1'b0; end
      endcase
   end
endmodule

// File: rtl/mbrf_bank.sv
module mbrf_bank #(
   parameter int WIDTH        = 32,
   parameter int NUM          = 5,
   parameter bit BANK0_STORED = 1'b1,
   localparam int IDX_W       = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] vals [NUM];

   if (NUM < 2) begin : g_bad_num
      $error("mbrf_bank: NUM must be at least 2");
   end

   for (genvar b = 0; b < NUM; b++) begin : g_entry
      if (b == 0 && !BANK0_STORED) begin : g_absent
         assign vals[b] = '0;
      end else begin : g_reg
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && widx == IDX_W'(b))
               q <= wdata;
         end
         assign vals[b] = q;
      end
   end

   assign rdata = (32'(ridx) < NUM) ? vals[ridx] : '0;

   // a write to a stored entry is visible on the read side at the next edge
   a_r6_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && 32'(widx) < NUM && (widx != '0 || BANK0_STORED) && ridx == widx)
      |=> rdata == $past(wdata));
endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
   import mbrf_pkg::*;
#(
   parameter int              DATA_W      = 32,
   parameter int              IRQ_BIT     = 7,
   parameter logic [DATA_W-1:0] VECTOR_ADDR = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  event_e            ev,
   input  logic              cur_has_saved,
   input  logic [DATA_W-1:0] saved_cur,
   input  logic [DATA_W-1:0] stat_wdata,
   input  logic [DATA_W-1:0] eret_pc,
   input  logic              eret_restore,
   output logic [DATA_W-1:0] status,
   output logic              pc_load_valid,
   output logic [DATA_W-1:0] pc_load,
   output logic              eret_err
);
   localparam logic [DATA_W-1:0] RESET_WORD =
      DATA_W'(MODE_SVC) | (DATA_W'(1) << IRQ_BIT);

   logic [DATA_W-1:0] st_q, st_n, pc_q, pc_n;
   logic              pcv_q, pcv_n, err_q, err_n;

   always_comb begin
      st_n  = st_q;
      pc_n  = pc_q;
      pcv_n = 1'b0;
      err_n = 1'b0;
      case (ev)
         EV_IRQ: begin
            st_n[MODE_W-1:0] = MODE_IRQ;
            st_n[IRQ_BIT]    = 1'b1;
            pcv_n            = 1'b1;
            pc_n             = VECTOR_ADDR;
         end
         EV_ERET: begin
            pcv_n = 1'b1;
            pc_n  = eret_pc;
            if (eret_restore) begin
               if (cur_has_saved) st_n  = saved_cur;
               else               err_n = 1'b1;
            end
         end
         EV_STAT: st_n = stat_wdata;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RESET_WORD;
         pc_q  <= '0;
         pcv_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         pc_q  <= pc_n;
         pcv_q <= pcv_n;
         err_q <= err_n;
      end
   end

   assign status        = st_q;
   assign pc_load       = pc_q;
   assign pc_load_valid = pcv_q;
   assign eret_err      = err_q;

   a_r3_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_IRQ |=> status[MODE_W-1:0] == MODE_IRQ && status[IRQ_BIT]);
   a_r5_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_IRQ |=> pc_load_valid && pc_load == VECTOR_ADDR);
   a_r7_stat_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_STAT |=> !pc_load_valid);
   a_r9_plain_return: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_ERET && !eret_restore) |=> $stable(status) && pc_load_valid);
   a_r10_no_saved: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_ERET && eret_restore && !cur_has_saved)
      |=> eret_err && $stable(status) && pc_load_valid);
   a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      eret_err |-> $past(ev == EV_ERET && eret_restore));
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
   import mbrf_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                IRQ_BIT     = 7,
   parameter logic [DATA_W-1:0] VECTOR_ADDR = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              irq_take,
   input  logic [DATA_W-1:0] irq_ret_addr,
   input  logic              call_take,
   input  logic [DATA_W-1:0] call_ret_addr,
   input  logic              eret_take,
   input  logic [DATA_W-1:0] eret_pc,
   input  logic              eret_restore,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   output logic [MODE_W-1:0] cur_mode,
   output logic [DATA_W-1:0] status,
   output logic              pc_load_valid,
   output logic [DATA_W-1:0] pc_load,
   output logic              eret_err
);
   if (DATA_W < 8) begin : g_bad_width
      $error("mode_bank_regfile: DATA_W must be at least 8");
   end
   if (IRQ_BIT < MODE_W || IRQ_BIT >= DATA_W) begin : g_bad_irq_bit
      $error("mode_bank_regfile: IRQ_BIT must lie above the mode field");
   end

   bank_e             cur_bank;
   logic              cur_has_saved;
   event_e            ev;
   logic [DATA_W-1:0] link_rd, saved_rd;
   logic              link_we, saved_we;
   logic [BANK_W-1:0] link_idx, saved_idx;
   logic [DATA_W-1:0] link_wd, saved_wd;

   assign cur_mode = status[MODE_W-1:0];

   mbrf_mode_decode u_decode (
      .mode      (cur_mode),
      .bank      (cur_bank),
      .has_saved (cur_has_saved)
   );

   // single event per cycle, fixed priority (R12)
   always_comb begin
      if      (irq_take)  ev = EV_IRQ;
      else if (eret_take) ev = EV_ERET;
      else if (call_take) ev = EV_CALL;
      else if (stat_we)   ev = EV_STAT;
      else if (reg_we)    ev = EV_PORT;
      else                ev = EV_NONE;
   end

   always_comb begin
      link_we  = (ev == EV_IRQ) || (ev == EV_CALL) || (ev == EV_PORT && !reg_sel);
      link_idx = (ev == EV_IRQ) ? BANK_IRQ : cur_bank;
      case (ev)
         EV_IRQ:  link_wd = irq_ret_addr;
         EV_CALL: link_wd = call_ret_addr;
         default: link_wd = reg_wdata;
      endcase
      saved_we  = (ev == EV_IRQ) || (ev == EV_PORT && reg_sel && cur_has_saved);
      saved_idx = (ev == EV_IRQ) ? BANK_IRQ : cur_bank;
      saved_wd  = (ev == EV_IRQ) ? status : reg_wdata;
   end

   mbrf_bank #(.WIDTH(DATA_W), .NUM(NUM_BANKS), .BANK0_STORED(1'b1)) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (link_we),
      .widx  (link_idx),
      .wdata (link_wd),
      .ridx  (cur_bank),
      .rdata (link_rd)
   );

   mbrf_bank #(.WIDTH(DATA_W), .NUM(NUM_BANKS), .BANK0_STORED(1'b0)) u_saved (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (saved_we),
      .widx  (saved_idx),
      .wdata (saved_wd),
      .ridx  (cur_bank),
      .rdata (saved_rd)
   );

   mbrf_status #(.DATA_W(DATA_W), .IRQ_BIT(IRQ_BIT), .VECTOR_ADDR(VECTOR_ADDR)) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev            (ev),
      .cur_has_saved (cur_has_saved),
      .saved_cur     (saved_rd),
      .stat_wdata    (stat_wdata),
      .eret_pc       (eret_pc),
      .eret_restore  (eret_restore),
      .status        (status),
      .pc_load_valid (pc_load_valid),
      .pc_load       (pc_load),
      .eret_err      (eret_err)
   );

   assign reg_rdata = reg_sel ? (cur_has_saved ? saved_rd : '0) : link_rd;

   a_r8_atomic_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_take && eret_restore && cur_has_saved && !irq_take)
      |=> status == $past(saved_rd) && pc_load_valid && pc_load == $past(eret_pc));
   a_r11_no_saved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && (cur_mode == MODE_USR || cur_mode == MODE_SYS)) |-> reg_rdata == '0);
   a_r4_irq_link: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (reg_sel || reg_rdata == $past(irq_ret_addr)));
endmodule

// File: tb/mode_bank_regfile_tb.sv
module mode_bank_regfile_tb;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_sel = 1'b0, reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic          irq_take = 1'b0, call_take = 1'b0, eret_take = 1'b0;
   logic          eret_restore = 1'b0, stat_we = 1'b0;
   logic [DW-1:0] irq_ret_addr = '0, call_ret_addr = '0, eret_pc = '0, stat_wdata = '0;
   logic [4:0]    cur_mode;
   logic [DW-1:0] status, pc_load;
   logic          pc_load_valid, eret_err;

   always #10 clk = ~clk;   // 50 MHz

   mode_bank_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_take(irq_take),
      .irq_ret_addr(irq_ret_addr), .call_take(call_take), .call_ret_addr(call_ret_addr),
      .eret_take(eret_take), .eret_pc(eret_pc), .eret_restore(eret_restore),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .cur_mode(cur_mode), .status(status),
      .pc_load_valid(pc_load_valid), .pc_load(pc_load), .eret_err(eret_err)
   );

   typedef enum int {K_STATUS, K_PCV, K_PC, K_ERR, K_RDATA, K_MODE} kind_e;
   typedef struct {
      kind_e         kind;
      logic [DW-1:0] exp;
      string         req;
   } item_t;

   item_t  exp_q[$];
   event   chk_ev;
   int     n_checks = 0;
   int     n_errors = 0;
   bit     finished = 1'b0;

   // reference model state
   logic [DW-1:0] m_st = 32'h93;
   logic [DW-1:0] m_lr [5] = '{default: '0};
   logic [DW-1:0] m_sv [5] = '{default: '0};

   function automatic int bank_of(logic [DW-1:0] st);
      case (st[4:0])
         5'b10010: return 1;
         5'b10011: return 2;
         5'b10111: return 3;
         5'b11011: return 4;
         default:  return 0;
      endcase
   endfunction

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            item_t it;
            logic [DW-1:0] act;
            it = exp_q.pop_front();
            case (it.kind)
               K_STATUS: act = status;
               K_PCV:    act = DW'(pc_load_valid);
               K_PC:     act = pc_load;
               K_ERR:    act = DW'(eret_err);
               K_MODE:   act = DW'(cur_mode);
               default:  act = reg_rdata;
            endcase
            n_checks++;
            if (act !== it.exp) begin
               n_errors++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   function automatic void push(kind_e k, logic [DW-1:0] e, string r);
      item_t it;
      it.kind = k; it.exp = e; it.req = r;
      exp_q.push_back(it);
   endfunction

   // driver: applies one cycle of stimulus, updates the model, queues expectations
   task automatic step(string req,
                       bit irq, logic [DW-1:0] ia,
                       bit call, logic [DW-1:0] ca,
                       bit eret, logic [DW-1:0] ep, bit er,
                       bit swe, logic [DW-1:0] sw,
                       bit rwe, bit rsel, logic [DW-1:0] rd);
      int  b;
      bit  has;
      bit  e_pcv;
      bit  e_err;
      logic [DW-1:0] e_pc;
      irq_take = irq; irq_ret_addr = ia;
      call_take = call; call_ret_addr = ca;
      eret_take = eret; eret_pc = ep; eret_restore = er;
      stat_we = swe; stat_wdata = sw;
      reg_we = rwe; reg_sel = rsel; reg_wdata = rd;
      b = bank_of(m_st);
      has = (b != 0);
      e_pcv = 1'b0; e_err = 1'b0; e_pc = '0;
      if (irq) begin
         m_sv[1] = m_st;
         m_lr[1] = ia;
         m_st = (m_st & ~32'h1F) | 32'h12 | 32'h80;
         e_pcv = 1'b1; e_pc = 32'h18;
      end else if (eret) begin
         e_pcv = 1'b1; e_pc = ep;
         if (er) begin
            if (has) m_st = m_sv[b];
            else     e_err = 1'b1;
         end
      end else if (call) begin
         m_lr[b] = ca;
      end else if (swe) begin
         m_st = sw;
      end else if (rwe) begin
         if (!rsel)    m_lr[b] = rd;
         else if (has) m_sv[b] = rd;
      end
      @(posedge clk);
      @(negedge clk);
      irq_take = 0; call_take = 0; eret_take = 0; eret_restore = 0;
      stat_we = 0; reg_we = 0; reg_sel = 0;
      b = bank_of(m_st);
      push(K_STATUS, m_st, req);
      push(K_MODE, DW'(m_st[4:0]), req);
      push(K_PCV, DW'(e_pcv), req);
      if (e_pcv) push(K_PC, e_pc, req);
      push(K_ERR, DW'(e_err), req);
      #1;
      push(K_RDATA, m_lr[b], req);
      -> chk_ev;
      #1 reg_sel = 1'b1;
      #1 push(K_RDATA, (b != 0) ? m_sv[b] : '0, req);
      -> chk_ev;
      #1 reg_sel = 1'b0;
   endtask

   task automatic idle(string req);
      step(req, 0, '0, 0, '0, 0, '0, 0, 0, '0, 0, 0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen before any event
      idle("R1");
      // R2: link write in supervisor mode
      step("R2", 0, '0, 0, '0, 0, '0, 0, 0, '0, 1, 0, 32'hA1A1_0001);
      // R6: call in supervisor mode
      step("R6", 0, '0, 1, 32'h0000_C100, 0, '0, 0, 0, '0, 0, 0, '0);
      // R11: saved-status write in supervisor mode
      step("R11", 0, '0, 0, '0, 0, '0, 0, 0, '0, 1, 1, 32'h0000_001F);
      // R3 R4 R5: interrupt entry from supervisor mode
      step("R3", 0 | 1, 32'h0000_0100, 0, '0, 0, '0, 0, 0, '0, 0, 0, '0);
      // R5: vector pulse lasts one cycle
      idle("R5");
      // R8: restore-flagged return goes back to supervisor; R4: supervisor link kept
      step("R8", 0, '0, 0, '0, 1, 32'h0000_0104, 1, 0, '0, 0, 0, '0);
      idle("R4");
      // R7: direct write to user mode
      step("R7", 0, '0, 0, '0, 0, '0, 0, 1, 32'h0000_0010, 0, 0, '0);
      // R11: saved-status write in user mode is ignored
      step("R11", 0, '0, 0, '0, 0, '0, 0, 0, '0, 1, 1, 32'hDEAD_BEEF);
      // R6: call in user mode
      step("R6", 0, '0, 1, 32'h0000_C200, 0, '0, 0, 0, '0, 0, 0, '0);
      // R2: system mode shares the user link copy
      step("R2", 0, '0, 0, '0, 0, '0, 0, 1, 32'h0000_001F, 0, 0, '0);
      // R10: restore-flagged return in system mode
      step("R10", 0, '0, 0, '0, 1, 32'h0000_0200, 1, 0, '0, 0, 0, '0);
      idle("R10");
      // R9: plain return
      step("R9", 0, '0, 0, '0, 1, 32'h0000_0300, 0, 0, '0, 0, 0, '0);
      // R12: interrupt and call together, interrupt wins, system link kept
      step("R12", 1, 32'h0000_0400, 1, 32'h0000_C300, 0, '0, 0, 1, 32'h0000_0017, 1, 0, 32'h5555_5555);
      // R3: saved status of interrupt mode now holds the system word
      step("R3", 0, '0, 0, '0, 1, 32'h0000_0404, 1, 0, '0, 0, 0, '0);
      // R12: status write beats port write
      step("R12", 0, '0, 0, '0, 0, '0, 0, 1, 32'h0000_0097, 1, 0, 32'h7777_0000);
      // R11 R8: abort mode saved status then restore from it
      step("R11", 0, '0, 0, '0, 0, '0, 0, 0, '0, 1, 1, 32'h0000_00D3);
      step("R8", 0, '0, 0, '0, 1, 32'h0000_0500, 1, 0, '0, 0, 0, '0);
      // R2: undefined mode has its own link copy
      step("R2", 0, '0, 0, '0, 0, '0, 0, 1, 32'h0000_001B, 0, 0, '0);
      step("R2", 0, '0, 0, '0, 0, '0, 0, 0, '0, 1, 0, 32'hBEEF_0005);
      // R7: return to supervisor by direct write shows the earlier call address
      step("R7", 0, '0, 0, '0, 0, '0, 0, 1, 32'h0000_0013, 0, 0, '0);
      #5;
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule